// File: doc/BRIEF.md
# Direct I/O Address Generator

This block forms the 16-bit device address used by the read-direct and write-direct instructions. A request carries the instruction's 17-bit address field, an index register value with a flag that selects indexing, a flag that selects indirection, and the processor's current mapping mode bit. The block accepts one request at a time through a valid/ready handshake. It then drives the finished address through a second valid/ready handshake.

If the request is indirect, the block first reads the indirect word through a simple read port. That port uses req/ack. The block raises a map-enable output with the read so that an external translation unit can map the fetch. The final device address is never mapped.

Indexing is done at 17 bits. The base is either the address field or the low 17 bits of the indirect word. The index register's low 17 bits are added to it, and any carry out of bit 16 is lost. Only the low 16 bits of the sum reach the output. Back-pressure rules: `req_ready` is high only while the block is idle, and a request is taken in the cycle where `req_valid` and `req_ready` are both high. Once `out_valid` rises, it stays high with a constant `out_addr` until the cycle in which `out_ready` is high.

Top module: `dio_addr_gen`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `mem_req`, `mem_map` and `out_valid` are 0.
- R2: A request with indexing and indirection both off gives `out_addr` equal to bits 15..0 of `req_field`, with `out_valid` high in the cycle after acceptance.
- R3: With indexing on, the result is bits 15..0 of (base + bits 16..0 of `req_index`) mod 2^17. Index bits above bit 16 and any carry out of bit 16 are discarded.
- R4: For an indirect request, `mem_req` rises in the cycle after acceptance, with `mem_addr` equal to the accepted `req_field`. `mem_req` and `mem_addr` then hold steady until the cycle in which `mem_ack` is high.
- R5: While `mem_req` is high, `mem_map` equals the `psw_map` value captured at acceptance. While `mem_req` is low, `mem_map` is 0. No mapping indication accompanies the final address.
- R6: In an indirect request, the base is bits 16..0 of `mem_rdata`, sampled in the `mem_ack` cycle. That base is indexed if indexing was selected, then truncated. `out_valid` rises in the cycle after the ack and `mem_req` drops. An ack that arrives while no read is pending is ignored.
- R7: `req_ready` is high and `busy` is low exactly when the block is idle. A `req_valid` presented while the block is busy is not taken, and `out_addr` is unchanged by it.
- R8: `out_valid` holds, with `out_addr` stable, until `out_ready` is high. The block is idle in the next cycle.
- R9: Changes to `req_field`, `req_index`, the flags or `psw_map` after acceptance do not affect the fetch or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_field | input | 17 | Instruction address field |
| req_indexed | input | 1 | Apply the index value |
| req_index | input | 32 | Index register value |
| req_indirect | input | 1 | Fetch an indirect word first |
| psw_map | input | 1 | Current mapping mode bit |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | Indirect word read pending |
| mem_addr | output | 17 | Address of the indirect word |
| mem_map | output | 1 | Translate the indirect word fetch |
| mem_ack | input | 1 | Read data present on mem_rdata |
| mem_rdata | input | 32 | Indirect word |
| out_valid | output | 1 | Final address valid |
| out_ready | input | 1 | Consumer takes the final address |
| out_addr | output | 16 | Final 16-bit device address |

## Verification
Two collisions matter most. The first is an output handshake that completes in the same cycle that `req_valid` is still asserted with fresh data. The bench holds `req_valid` high through the whole busy period and through that handshake cycle. It expects the request to be refused every cycle, followed by an idle cycle with no acceptance. The second is a read acknowledge that arrives while the result waits for back-pressure. The bench pulses `mem_ack` with junk data during stalled output cycles and expects `out_addr` to stay stable. A behavioural model, advanced on every clock, predicts every output, and the bench compares each prediction with the design.

// File: rtl/dio_pkg.sv
package dio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_OUT   = 2'd2
  } dio_state_e;

  typedef struct packed {
    logic indexed;
    logic indirect;
    logic map_en;
  } dio_flags_t;

endpackage

// File: rtl/dio_ctrl.sv
module dio_ctrl
  import dio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_indirect,
  input  logic       mem_ack,
  input  logic       out_ready,
  output dio_state_e state,
  output logic       accept,
  output logic       load_out
);

  dio_state_e state_d;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign load_out = (accept && !req_indirect) || ((state == ST_FETCH) && mem_ack);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (accept) state_d = req_indirect ? ST_FETCH : ST_OUT;
      ST_FETCH: if (mem_ack) state_d = ST_OUT;
      ST_OUT:   if (out_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state != ST_IDLE)); // R7

  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3); // R7

endmodule

// File: rtl/dio_fetch_port.sv
module dio_fetch_port #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              map_in,
  input  logic              pending,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_map
);

  logic [ADDR_W-1:0] addr_q;
  logic              map_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      map_q  <= 1'b0;
    end else if (capture) begin
      addr_q <= addr_in;
      map_q  <= map_in;
    end
  end

  assign mem_req  = pending;
  assign mem_addr = addr_q;
  assign mem_map  = pending && map_q;

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_map))); // R4

endmodule

// File: rtl/dio_index_unit.sv
module dio_index_unit #(
  parameter int FIELD_W = 17,
  parameter int IDX_W   = 32,
  parameter int WORD_W  = 32,
  parameter int OUT_W   = 16
) (
  input  logic               use_word,
  input  logic [FIELD_W-1:0] field,
  input  logic [WORD_W-1:0]  word,
  input  logic               indexed,
  input  logic [IDX_W-1:0]   index,
  output logic [OUT_W-1:0]   addr
);

  logic [FIELD_W-1:0] word_lo;
  logic [FIELD_W-1:0] idx_lo;
  logic [FIELD_W-1:0] base;
  logic [FIELD_W-1:0] sum;

  generate
    if (WORD_W >= FIELD_W) begin : g_word_wide
      assign word_lo = word[FIELD_W-1:0];
      if (WORD_W > FIELD_W) begin : g_word_drop
        logic unused_word_hi;
        assign unused_word_hi = ^word[WORD_W-1:FIELD_W];
      end
    end else begin : g_word_narrow
      assign word_lo = {{(FIELD_W-WORD_W){1'b0}}, word};
    end

    if (IDX_W >= FIELD_W) begin : g_idx_wide
      assign idx_lo = index[FIELD_W-1:0];
      if (IDX_W > FIELD_W) begin : g_idx_drop
        logic unused_idx_hi;
        assign unused_idx_hi = ^index[IDX_W-1:FIELD_W];
      end
    end else begin : g_idx_narrow
      assign idx_lo = {{(FIELD_W-IDX_W){1'b0}}, index};
    end
  endgenerate

  assign base = use_word ? word_lo : field;
  assign sum  = indexed ? (base + idx_lo) : base;
  assign addr = sum[OUT_W-1:0];

  logic unused_sum_hi;
  assign unused_sum_hi = ^sum[FIELD_W-1:OUT_W];

endmodule

// File: rtl/dio_out_stage.sv
module dio_out_stage #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] addr_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= addr_in;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R8

  AST_NO_LOAD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid); // R8

endmodule

// File: rtl/dio_addr_gen.sv
module dio_addr_gen
  import dio_pkg::*;
#(
  parameter int FIELD_W = 17,
  parameter int IDX_W   = 32,
  parameter int WORD_W  = 32,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FIELD_W-1:0] req_field,
  input  logic               req_indexed,
  input  logic [IDX_W-1:0]   req_index,
  input  logic               req_indirect,
  input  logic               psw_map,
  output logic               busy,
  output logic               mem_req,
  output logic [FIELD_W-1:0] mem_addr,
  output logic               mem_map,
  input  logic               mem_ack,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_addr
);

  dio_state_e          state;
  logic                accept;
  logic                load_out;
  dio_flags_t          flags_q;
  logic [IDX_W-1:0]    index_q;
  logic                live;
  logic                sel_indexed;
  logic [IDX_W-1:0]    sel_index;
  logic [OUT_W-1:0]    next_addr;

  dio_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_indirect (req_indirect),
    .mem_ack      (mem_ack),
    .out_ready    (out_ready),
    .state        (state),
    .accept       (accept),
    .load_out     (load_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      index_q <= '0;
    end else if (accept) begin
      flags_q <= '{indexed: req_indexed, indirect: req_indirect, map_en: psw_map};
      index_q <= req_index;
    end
  end

  dio_fetch_port #(.ADDR_W(FIELD_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .addr_in  (req_field),
    .map_in   (psw_map),
    .pending  (state == ST_FETCH),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_map  (mem_map)
  );

  assign live        = (state == ST_IDLE);
  assign sel_indexed = live ? req_indexed : flags_q.indexed;
  assign sel_index   = live ? req_index   : index_q;

  dio_index_unit #(
    .FIELD_W (FIELD_W),
    .IDX_W   (IDX_W),
    .WORD_W  (WORD_W),
    .OUT_W   (OUT_W)
  ) u_index (
    .use_word (!live),
    .field    (req_field),
    .word     (mem_rdata),
    .indexed  (sel_indexed),
    .index    (sel_index),
    .addr     (next_addr)
  );

  dio_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_out),
    .addr_in   (next_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_addr  (out_addr)
  );

  assign req_ready = live;
  assign busy      = !live;

  logic unused_flag;
  assign unused_flag = flags_q.indirect ^ flags_q.map_en;

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!out_valid && !mem_req)); // R7

  AST_NO_FETCH_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && out_valid)); // R6

  AST_ACK_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (out_valid && !mem_req)); // R6

endmodule

// File: tb/dio_addr_gen_bench.sv
module dio_addr_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_field = '0;
  logic        req_indexed = 1'b0;
  logic [31:0] req_index = '0;
  logic        req_indirect = 1'b0;
  logic        psw_map = 1'b0;
  logic        busy;
  logic        mem_req;
  logic [16:0] mem_addr;
  logic        mem_map;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_addr_gen u_dio_addr_gen (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_field (req_field), .req_indexed (req_indexed),
    .req_index (req_index), .req_indirect (req_indirect),
    .psw_map (psw_map), .busy (busy),
    .mem_req (mem_req), .mem_addr (mem_addr), .mem_map (mem_map),
    .mem_ack (mem_ack), .mem_rdata (mem_rdata),
    .out_valid (out_valid), .out_ready (out_ready), .out_addr (out_addr)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural model state: 0 idle, 1 fetching, 2 holding result
  int          m_phase = 0;
  logic [16:0] m_field = '0;
  logic [31:0] m_idx = '0;
  bit          m_indexed = 0;
  bit          m_map = 0;
  logic [15:0] m_out = '0;
  string       m_tag = "R2";
  string       job_tag = "R2";
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [15:0] model_addr(logic [31:0] base, bit idx_on, logic [31:0] idx);
    longint s;
    s = base & 32'h1FFFF;
    if (idx_on) s = (s + (idx & 32'h1FFFF)) % 131072;
    return s[15:0];
  endfunction

  function automatic logic [31:0] word_of(logic [16:0] a);
    return {a[14:0], a} ^ 32'hA5C3_1E07;
  endfunction

  task automatic check(string rq, string nm, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R7", "req_ready", req_ready, m_phase == 0);
    check("R7", "busy", busy, m_phase != 0);
    check("R4", "mem_req", mem_req, m_phase == 1);
    check("R5", "mem_map", mem_map, (m_phase == 1) && m_map);
    check("R8", "out_valid", out_valid, m_phase == 2);
    if (m_phase == 1) check("R4", "mem_addr", mem_addr, m_field);
    if (m_phase == 2) check(m_tag, "out_addr", out_addr, m_out);
  endtask

  task automatic cycle();
    case (m_phase)
      0: if (req_valid) begin
        m_field = req_field; m_idx = req_index; m_indexed = req_indexed;
        m_map = psw_map; m_tag = job_tag;
        if (req_indirect) m_phase = 1;
        else begin
          m_out = model_addr({15'd0, req_field}, req_indexed, req_index);
          m_phase = 2;
        end
      end
      1: if (mem_ack) begin
        m_out = model_addr(mem_rdata, m_indexed, m_idx);
        m_phase = 2;
      end
      default: if (out_ready) m_phase = 0;
    endcase
    @(posedge clk);
    #2;
    compare_all();
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // noisy: req_valid stays high with other data while busy; spurious acks during output stall
  task automatic run_job(logic [16:0] f, bit ix, logic [31:0] iv, bit ind, bit mp,
                         int ack_lat, int out_lat, bit noisy, bit scramble);
    req_valid = 1; req_field = f; req_indexed = ix; req_index = iv;
    req_indirect = ind; psw_map = mp;
    cycle();
    if (!noisy) req_valid = 0;
    if (scramble || noisy) begin
      req_field = ~f; req_index = ~iv; req_indexed = !ix;
      req_indirect = !ind; psw_map = !mp;
    end
    if (ind) begin
      for (int i = 0; i < ack_lat; i++) cycle();
      mem_ack = 1; mem_rdata = word_of(f);
      cycle();
      mem_ack = 0; mem_rdata = rnd();
    end
    for (int i = 0; i < out_lat; i++) begin
      if (noisy) begin mem_ack = 1; mem_rdata = rnd(); end
      cycle();
    end
    mem_ack = 0;
    out_ready = 1;
    cycle();
    out_ready = 0; req_valid = 0;
    cycle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "req_ready", req_ready, 1);
    check("R1", "busy", busy, 0);
    check("R1", "mem_req", mem_req, 0);
    check("R1", "mem_map", mem_map, 0);
    check("R1", "out_valid", out_valid, 0);
    rst_n = 1;
    cycle();

    job_tag = "R2"; run_job(17'h1_2345, 0, 32'hFFFF_FFFF, 0, 1, 0, 0, 0, 0);
    job_tag = "R2"; run_job(17'h0_00FF, 0, 32'h0000_0001, 0, 0, 0, 2, 0, 0);
    job_tag = "R3"; run_job(17'h0_FFFF, 1, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
    job_tag = "R3"; run_job(17'h1_FFFF, 1, 32'hFFFF_0002, 0, 1, 0, 1, 0, 0);
    job_tag = "R6"; run_job(17'h0_4000, 0, 32'h0000_0010, 1, 1, 3, 0, 0, 0);
    job_tag = "R6"; run_job(17'h1_8001, 1, 32'h1234_FFFF, 1, 0, 0, 0, 0, 0);
    job_tag = "R7"; run_job(17'h0_0A0A, 1, 32'h0000_0505, 1, 1, 2, 4, 1, 0);
    job_tag = "R7"; run_job(17'h0_7777, 0, 32'h0000_0000, 0, 0, 0, 3, 1, 0);
    job_tag = "R9"; run_job(17'h1_0F0F, 1, 32'h0001_1111, 1, 1, 1, 1, 0, 1);
    job_tag = "R9"; run_job(17'h0_3C3C, 1, 32'h0002_0003, 0, 0, 0, 1, 0, 1);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a, b, c;
      a = rnd(); b = rnd(); c = rnd();
      job_tag = a[0] ? "R6" : (a[1] ? "R3" : "R2");
      run_job(b[16:0], a[1], c, a[0], a[2], int'(a[5:4]), int'(a[7:6]), a[8], a[9]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule